// File: doc/BRIEF.md
# Hiccup Fault Protection Supervisor

This block decides, clock by clock, whether the power stage of a switching regulator may switch. It takes comparator results that are already digital: a peak current-limit pulse that can fire once per switching period, a marker for the end of each switching period, and levels for input under-voltage, input over-voltage and over-temperature. It also takes a master enable.

A run of current-limited switching periods with no clean period between them is counted. When the run reaches a parameterised length, the stage is forced into tri-state for a fixed number of clocks. When that wait ends, the block asks for a fresh soft-start if switching is allowed, and otherwise falls back to idle. The over-voltage level passes through a filter, so a short spike has no effect. The three fault levels are also brought out as status bits for a status register.

Every resume of switching produces a single-clock soft-start request, whether it follows enable, a cleared fault or the end of a hiccup wait. All outputs come from registers.

Top module: `hiccup_supervisor`

## Requirements
- R1: While `rst` is high, and on the clock that follows it, `sw_allow`, `stage_tristate`, `ss_req`, `stat_uv`, `stat_ov` and `stat_ot` are all 0.
- R2: From idle, if `en` is 1 and no fault is present on a clock edge, `sw_allow` is 1 after that edge. `ss_req` is 1 for exactly that one clock.
- R3: A switching period counts as limited if `ilim` was 1 on any clock of the period, including the clock that carries `cyc_end`. A `cyc_end` of a period with no `ilim` sets the run count back to zero.
- R4: Take the edge that samples the `cyc_end` of the LIMIT_CYCLES-th consecutive limited period. After that edge, `sw_allow` is 0 and `stage_tristate` is 1. One period fewer leaves switching running.
- R5: `stage_tristate` stays 1 for exactly OFF_CYCLES clocks, and `sw_allow` is 0 throughout. Changes of `en` or of the faults during the wait do not shorten it.
- R6: When the wait ends, switching resumes with a one-clock `ss_req` if `en` is 1 and no fault is present. Otherwise the block goes to idle with `sw_allow`, `stage_tristate` and `ss_req` all 0.
- R7: `stat_ov` becomes 1 after the OV_FILT_CLKS-th consecutive edge that samples `ov_in` high. It returns to 0 after the first edge that samples `ov_in` low. A shorter burst changes neither `stat_ov` nor `sw_allow`.
- R8: `stat_uv` follows `uv_in` with one clock of delay. While `uv_in` is 1, `sw_allow` is 0 on the next clock.
- R9: `stat_ot` follows `ot_in` with one clock of delay. Over-temperature stops switching. When it clears, switching resumes with a new `ss_req`.
- R10: When `en` is 0 on an edge, `sw_allow` is 0 after that edge. Outside a hiccup wait, `stage_tristate` stays 0.
- R11: Suppose a fault and the trip condition of R4 arrive on the same edge. The block goes to idle, not to the hiccup wait.
- R12: `ilim` and `cyc_end` have no effect while switching is stopped. After a resume, a full run of LIMIT_CYCLES limited periods is needed to trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Master enable for the regulator |
| cyc_end | input | 1 | One-clock marker at the end of each switching period |
| ilim | input | 1 | Peak current-limit comparator pulse |
| uv_in | input | 1 | Input under-voltage level (already includes hysteresis) |
| ov_in | input | 1 | Raw input over-voltage level |
| ot_in | input | 1 | Over-temperature level (already includes hysteresis) |
| sw_allow | output | 1 | Power stage may switch |
| stage_tristate | output | 1 | Power stage held in tri-state (hiccup wait) |
| ss_req | output | 1 | One-clock request to start a soft-start |
| stat_uv | output | 1 | Under-voltage status bit |
| stat_ov | output | 1 | Filtered over-voltage status bit |
| stat_ot | output | 1 | Over-temperature status bit |

## Verification
`sw_allow`, `stage_tristate` and `ss_req` pass through one register from the edge that samples the deciding inputs, so they are due one clock after a stimulus. `stat_uv` and `stat_ot` also lag their inputs by one clock. `stat_ov` needs OV_FILT_CLKS sampled highs. The bench changes inputs on falling edges and keeps a behavioural model that advances on each rising edge. It compares every output at the next falling edge, once the edge has settled. It also adds directed checks at the same falling-edge points, for example right after the `cyc_end` that should trip, and at each clock of the tri-state window, so the window length is counted exactly.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_HICCUP = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_ilim_counter.sv
// Counts consecutive switching periods that saw a current-limit pulse.
module hs_ilim_counter #(
  parameter int LIMIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic cyc_end,
  input  logic ilim,
  output logic trip
);
  localparam int CW = (LIMIT_CYCLES > 1) ? $clog2(LIMIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          seen;
  logic          hit;

  assign hit  = seen | ilim;
  assign trip = active & cyc_end & hit & (run_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      run_cnt <= '0;
      seen    <= 1'b0;
    end else if (cyc_end) begin
      seen <= 1'b0;
      if (!hit)                 run_cnt <= '0;
      else if (run_cnt == LAST) run_cnt <= '0;
      else                      run_cnt <= run_cnt + 1'b1;
    end else begin
      seen <= hit;
    end
  end
endmodule

// File: rtl/hs_ov_filter.sv
// Passes the over-voltage level only after it has been high for FILT_CLKS samples.
module hs_ov_filter #(
  parameter int FILT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ov_raw,
  output logic ov_flt
);
  generate
    if (FILT_CLKS < 2) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) ov_flt <= 1'b0;
        else     ov_flt <= ov_raw;
      end
    end else begin : g_count
      localparam int FW = $clog2(FILT_CLKS);
      localparam logic [FW-1:0] LAST = FW'(FILT_CLKS - 1);
      logic [FW-1:0] hi_cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_cnt <= '0;
          ov_flt <= 1'b0;
        end else begin
          ov_flt <= ov_raw && (hi_cnt == LAST);
          if (!ov_raw)              hi_cnt <= '0;
          else if (hi_cnt != LAST)  hi_cnt <= hi_cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hs_off_timer.sv
// Down-counter that measures the tri-state wait.
module hs_off_timer #(
  parameter int OFF_CYCLES = 85000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int TW = (OFF_CYCLES > 1) ? $clog2(OFF_CYCLES) : 1;
  localparam logic [TW-1:0] LOADV = TW'(OFF_CYCLES - 1);

  logic [TW-1:0] left;

  assign expired = run && (left == '0);

  always_ff @(posedge clk) begin
    if (rst)                      left <= '0;
    else if (load)                left <= LOADV;
    else if (run && left != '0)   left <= left - 1'b1;
  end
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor #(
  parameter int LIMIT_CYCLES = 16,
  parameter int OFF_CYCLES   = 85000,
  parameter int OV_FILT_CLKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cyc_end,
  input  logic ilim,
  input  logic uv_in,
  input  logic ov_in,
  input  logic ot_in,
  output logic sw_allow,
  output logic stage_tristate,
  output logic ss_req,
  output logic stat_uv,
  output logic stat_ov,
  output logic stat_ot
);
  import hs_pkg::*;

  hs_state_e state_q, state_n;
  logic      trip;
  logic      expired;
  logic      ov_flt;
  logic      fault;
  logic      go_ok;
  logic      load_timer;

  hs_ilim_counter #(.LIMIT_CYCLES(LIMIT_CYCLES)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .active  (state_q == ST_RUN),
    .cyc_end (cyc_end),
    .ilim    (ilim),
    .trip    (trip)
  );

  hs_ov_filter #(.FILT_CLKS(OV_FILT_CLKS)) u_ovf (
    .clk    (clk),
    .rst    (rst),
    .ov_raw (ov_in),
    .ov_flt (ov_flt)
  );

  hs_off_timer #(.OFF_CYCLES(OFF_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (load_timer),
    .run     (state_q == ST_HICCUP),
    .expired (expired)
  );

  assign fault = uv_in | ov_flt | ot_in;
  assign go_ok = en & ~fault;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:   if (go_ok) state_n = ST_RUN;
      ST_RUN: begin
        if (!go_ok)    state_n = ST_IDLE;
        else if (trip) state_n = ST_HICCUP;
      end
      ST_HICCUP: if (expired) state_n = go_ok ? ST_RUN : ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  assign load_timer = (state_q == ST_RUN) && (state_n == ST_HICCUP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      sw_allow       <= 1'b0;
      stage_tristate <= 1'b0;
      ss_req         <= 1'b0;
      stat_uv        <= 1'b0;
      stat_ot        <= 1'b0;
    end else begin
      state_q        <= state_n;
      sw_allow       <= (state_n == ST_RUN);
      stage_tristate <= (state_n == ST_HICCUP);
      ss_req         <= (state_n == ST_RUN) && (state_q != ST_RUN);
      stat_uv        <= uv_in;
      stat_ot        <= ot_in;
    end
  end

  assign stat_ov = ov_flt;
endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic uv_in,
  input logic ov_in,
  input logic ot_in,
  input logic sw_allow,
  input logic stage_tristate,
  input logic ss_req,
  input logic stat_ov
);
  // R5
  tri_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_allow && stage_tristate));
  // R4
  tri_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stage_tristate) |-> $past(sw_allow));
  // R2
  ss_on_resume_chk: assert property (@(posedge clk) disable iff (rst)
    ss_req |-> (sw_allow && !$past(sw_allow)));
  // R2
  ss_single_chk: assert property (@(posedge clk) disable iff (rst)
    ss_req |=> !ss_req);
  // R8
  uv_block_chk: assert property (@(posedge clk) disable iff (rst)
    uv_in |=> !sw_allow);
  // R9
  ot_block_chk: assert property (@(posedge clk) disable iff (rst)
    ot_in |=> !sw_allow);
  // R7
  ov_block_chk: assert property (@(posedge clk) disable iff (rst)
    stat_ov |=> !sw_allow);
  // R7
  ov_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_ov) |-> $past(ov_in));
  // R10
  en_block_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sw_allow);
endmodule

bind hiccup_supervisor hiccup_supervisor_chk chk_i (
  .clk            (clk),
  .rst            (rst),
  .en             (en),
  .uv_in          (uv_in),
  .ov_in          (ov_in),
  .ot_in          (ot_in),
  .sw_allow       (sw_allow),
  .stage_tristate (stage_tristate),
  .ss_req         (ss_req),
  .stat_ov        (stat_ov)
);

// File: tb/hiccup_supervisor_tb_top.sv
`timescale 1ns/1ps
module hiccup_supervisor_tb_top;
  localparam int LIM = 16;
  localparam int OFF = 40;
  localparam int OVF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, cyc_end = 1'b0, ilim = 1'b0;
  logic uv_in = 1'b0, ov_in = 1'b0, ot_in = 1'b0;
  logic sw_allow, stage_tristate, ss_req, stat_uv, stat_ov, stat_ot;

  always #10 clk = ~clk;

  hiccup_supervisor #(.LIMIT_CYCLES(LIM), .OFF_CYCLES(OFF), .OV_FILT_CLKS(OVF)) dut_i (
    .clk(clk), .rst(rst), .en(en), .cyc_end(cyc_end), .ilim(ilim),
    .uv_in(uv_in), .ov_in(ov_in), .ot_in(ot_in),
    .sw_allow(sw_allow), .stage_tristate(stage_tristate), .ss_req(ss_req),
    .stat_uv(stat_uv), .stat_ov(stat_ov), .stat_ot(stat_ot)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference model: 0 idle, 1 switching, 2 waiting
  int m_mode = 0, m_run = 0, m_seen = 0, m_wait = 0, m_ovc = 0;
  int m_ovf = 0, m_uv = 0, m_ot = 0, m_ss = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_run = 0; m_seen = 0; m_wait = 0; m_ovc = 0;
      m_ovf = 0; m_uv = 0; m_ot = 0; m_ss = 0;
    end else begin
      int ok, hit, tripped, nxt, exp_done;
      ok = en && !uv_in && !ot_in && (m_ovf == 0);
      hit = m_seen || ilim;
      tripped = (m_mode == 1) && cyc_end && hit && (m_run == LIM - 1);
      exp_done = (m_mode == 2) && (m_wait == 0);
      nxt = m_mode;
      if (m_mode == 0 && ok) nxt = 1;
      else if (m_mode == 1 && !ok) nxt = 0;
      else if (m_mode == 1 && tripped) nxt = 2;
      else if (exp_done) nxt = ok ? 1 : 0;
      m_ss = (nxt == 1) && (m_mode != 1);
      if (m_mode != 1) begin m_run = 0; m_seen = 0; end
      else if (cyc_end) begin m_run = hit ? m_run + 1 : 0; m_seen = 0; end
      else m_seen = hit;
      if (m_mode == 1 && nxt == 2) m_wait = OFF - 1;
      else if (m_mode == 2 && m_wait > 0) m_wait = m_wait - 1;
      m_ovf = (ov_in && m_ovc >= OVF - 1) ? 1 : 0;
      m_ovc = ov_in ? ((m_ovc < OVF - 1) ? m_ovc + 1 : m_ovc) : 0;
      m_uv = uv_in; m_ot = ot_in;
      m_mode = nxt;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(phase, "sw_allow", int'(sw_allow), int'(m_mode == 1));
      chk(phase, "stage_tristate", int'(stage_tristate), int'(m_mode == 2));
      chk(phase, "ss_req", int'(ss_req), m_ss);
      chk("R8", "stat_uv", int'(stat_uv), m_uv);
      chk("R7", "stat_ov", int'(stat_ov), m_ovf);
      chk("R9", "stat_ot", int'(stat_ot), m_ot);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one switching period of four clocks; returns at the falling edge after cyc_end
  task automatic period(input bit lim, input bit on_end, input bit uv_end);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ilim = lim && ((k == 1 && !on_end) || (k == 3 && on_end));
      cyc_end = (k == 3);
      if (uv_end && k == 3) uv_in = 1'b1;
    end
    @(negedge clk);
    ilim = 1'b0; cyc_end = 1'b0;
  endtask

  task automatic limited(input int n);
    for (int i = 0; i < n; i++) period(1'b1, (i % 3) == 2, 1'b0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    int n;
    tick(3);
    chk("R1", "outputs in reset", int'({sw_allow, stage_tristate, ss_req, stat_uv, stat_ov, stat_ot}), 0);
    rst = 1'b0;
    tick(1);
    chk("R1", "outputs after reset", int'({sw_allow, stage_tristate, ss_req, stat_uv, stat_ov, stat_ot}), 0);
    cmp_on = 1;

    phase = "R2"; en = 1'b1;
    tick(1);
    chk("R2", "sw_allow after enable", int'(sw_allow), 1);
    chk("R2", "ss_req after enable", int'(ss_req), 1);
    tick(2);

    phase = "R3";
    limited(10);
    period(1'b0, 1'b0, 1'b0);
    limited(LIM - 1);
    chk("R3", "still switching after clean break", int'(sw_allow), 1);

    phase = "R4";
    period(1'b1, 1'b0, 1'b0);
    chk("R4", "tri-state after full run", int'(stage_tristate), 1);
    chk("R4", "switching off after full run", int'(sw_allow), 0);

    phase = "R5"; n = 0;
    while (stage_tristate && n < 10 * OFF) begin
      n++;
      if (n == 5) en = 1'b0;
      if (n == 10) en = 1'b1;
      @(negedge clk);
    end
    chk("R5", "tri-state clocks", n, OFF);
    chk("R6", "resume sw_allow", int'(sw_allow), 1);
    chk("R6", "resume ss_req", int'(ss_req), 1);
    tick(2);

    phase = "R12"; en = 1'b0;
    tick(2);
    limited(20);
    en = 1'b1;
    tick(2);
    limited(LIM - 1);
    chk("R12", "no trip after idle pulses", int'(stage_tristate), 0);
    chk("R12", "still switching", int'(sw_allow), 1);
    period(1'b0, 1'b0, 1'b0);

    phase = "R7"; ov_in = 1'b1;
    tick(OVF - 1);
    ov_in = 1'b0;
    tick(2);
    chk("R7", "short spike stat_ov", int'(stat_ov), 0);
    chk("R7", "short spike sw_allow", int'(sw_allow), 1);
    ov_in = 1'b1;
    tick(OVF);
    chk("R7", "stat_ov after filter", int'(stat_ov), 1);
    tick(3);
    chk("R7", "switching stopped by ov", int'(sw_allow), 0);
    ov_in = 1'b0;
    tick(1);
    chk("R7", "stat_ov release", int'(stat_ov), 0);
    tick(3);

    phase = "R9"; ot_in = 1'b1;
    tick(1);
    chk("R9", "stat_ot", int'(stat_ot), 1);
    tick(4);
    ot_in = 1'b0;
    tick(2);
    chk("R9", "resume after ot", int'(sw_allow), 1);
    tick(2);

    phase = "R11";
    limited(LIM - 1);
    period(1'b1, 1'b0, 1'b1);
    chk("R11", "fault wins over trip: tristate", int'(stage_tristate), 0);
    chk("R11", "fault wins over trip: sw_allow", int'(sw_allow), 0);
    uv_in = 1'b0;
    tick(3);

    phase = "R6";
    limited(LIM);
    chk("R6", "second trip", int'(stage_tristate), 1);
    uv_in = 1'b1;
    tick(OFF + 2);
    chk("R6", "idle after wait with fault", int'({sw_allow, stage_tristate, ss_req}), 0);
    phase = "R8"; uv_in = 1'b0;
    tick(2);
    chk("R8", "resume after uv clears", int'(sw_allow), 1);
    tick(2);

    phase = "R10"; en = 1'b0;
    tick(1);
    chk("R10", "sw_allow after en low", int'(sw_allow), 0);
    chk("R10", "no tristate on disable", int'(stage_tristate), 0);
    tick(3);

    done = 1;
    summary();
  end
endmodule